// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

An 8-bit counter that serves two purposes, chosen by a mode bit in its control register. As an event counter it counts transitions of one selected direction on an external input pin. As a gated-time accumulator it adds one for every tick of an internal time base, but only while the input sits at its non-inhibiting level. One polarity bit chooses the counted edge in event mode and the inhibiting level in gated mode.

Software sees two registers on a small synchronous bus. One is a control register and the other is the count register. The control register also holds a capture/compare select bit and two rate-select bits. The block only stores these bits for neighbouring logic. The external pin is synchronized before use. An overflow strobe marks each wrap of the counter.

Top module: `pulse_accum`

## Requirements
- R1: After reset the control register reads 0x00. Its bits are: bit 6 enable, bit 5 mode (0 event, 1 gated), bit 4 polarity, bit 2 capture/compare select, bits 1:0 rate select. Bits 7 and 3 always read zero, so writing 0xFF reads back 0x77.
- R2: Bus address 0 selects the control register and address 1 selects the count register. Read data follows the address combinationally. A write takes effect at the clock edge where the write enable is high.
- R3: With the enable bit at 0, no input activity and no time-base tick changes the count.
- R4: In event mode with polarity 0, each falling transition of the input adds one and a rising transition adds nothing.
- R5: In event mode with polarity 1, each rising transition of the input adds one and a falling transition adds nothing.
- R6: In gated mode the count adds one on each tick of a free-running divide-by-64 prescaler while the gate is open. With polarity 0 a low input closes the gate, so a high level held for 64·N cycles yields exactly N counts.
- R7: In gated mode with polarity 1 a high input closes the gate and a low input opens it.
- R8: The count register can be read and written at any time. A write that lands in the same cycle as an increment wins, and the count never moves by more than one per cycle.
- R9: Reset leaves the count register unchanged.
- R10: An increment from 0xFF to 0x00 raises the overflow output for exactly one cycle, during which the count reads 0x00. A bus write never raises it.
- R11: The input passes through two synchronizing flops. An input change sampled at clock edge k is counted at edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset of control, synchronizer and prescaler |
| busAddr | input | 1 | Register select: 0 control, 1 count |
| busWr | input | 1 | Write enable |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed register |
| pulseIn | input | 1 | External asynchronous input pin |
| ovfPulse | output | 1 | One-cycle strobe on counter wrap |

## Verification
Event counting is driven with a single held rise followed by a fall, in both polarities. The count is read between the two transitions, which shows whether the right edge was picked or both edges were counted. Gated mode uses open windows that are exact multiples of the prescaler period in each polarity, plus long closed stretches. This separates the tick rate, the sense of the gate and the inhibit function without knowing the prescaler phase. Back-to-back count writes over a whole prescaler period force a write to collide with a tick. A count run from 0xFE through the wrap shows the overflow strobe and that only the wrapping increment raises it.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 1'b1;

  // bit positions inside the control register
  localparam int BIT_EN   = 6;
  localparam int BIT_MODE = 5;
  localparam int BIT_POL  = 4;
  localparam int BIT_CC   = 2;
  localparam int RATE_LO  = 0;
  localparam int RATE_W   = 2;

  typedef struct packed {
    logic              enable;
    logic              gated;
    logic              polarity;
    logic              ccSel;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  typedef struct packed {
    logic incr;
    logic load;
  } strobe_t;
endpackage

// File: rtl/pacc_ctrl.sv
module pacc_ctrl
  import pacc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              pulseIn,
  output ctrl_t             ctrlQ,
  output strobe_t           strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [PRESCALE_W-1:0]  presQ;
  logic                   syncLevel;
  logic                   riseHit;
  logic                   fallHit;
  logic                   tick;
  logic                   gateOpen;
  logic                   eventHit;
  logic                   ctrlWr;
  logic [1:0]             unusedBits;

  assign unusedBits = {busWdata[7], busWdata[3]};

  // synchronizer chain
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= pulseIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign syncLevel = syncQ[LAST];

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncLevel;
  end

  assign riseHit = syncLevel & ~prevQ;
  assign fallHit = ~syncLevel & prevQ;

  // free-running time base
  always_ff @(posedge clk) begin
    if (!rstN) presQ <= '0;
    else       presQ <= presQ + 1'b1;
  end

  assign tick = &presQ;

  // control register
  assign ctrlWr = busWr && (busAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ.enable   <= busWdata[BIT_EN];
      ctrlQ.gated    <= busWdata[BIT_MODE];
      ctrlQ.polarity <= busWdata[BIT_POL];
      ctrlQ.ccSel    <= busWdata[BIT_CC];
      ctrlQ.rate     <= busWdata[RATE_LO +: RATE_W];
    end
  end

  // polarity: edge select in event mode, inhibit level in gated mode
  assign gateOpen = syncLevel ^ ctrlQ.polarity;
  assign eventHit = ctrlQ.polarity ? riseHit : fallHit;

  always_comb begin
    strobe.load = busWr && (busAddr == ADDR_COUNT);
    strobe.incr = ctrlQ.enable &&
                  (ctrlQ.gated ? (tick && gateOpen) : eventHit);
  end
endmodule

// File: rtl/pacc_datapath.sv
module pacc_datapath
  import pacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  ctrl_t             ctrlQ,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] countQ,
  output logic              ovfPulse
);
  logic [DATA_W-1:0] ctrlView;
  logic              wrapping;

  // count register: untouched by reset; bus load has priority
  always_ff @(posedge clk) begin
    if (strobe.load)      countQ <= busWdata;
    else if (strobe.incr) countQ <= countQ + 1'b1;
  end

  assign wrapping = strobe.incr && !strobe.load && (&countQ);

  always_ff @(posedge clk) begin
    if (!rstN) ovfPulse <= 1'b0;
    else       ovfPulse <= wrapping;
  end

  always_comb begin
    ctrlView                       = '0;
    ctrlView[BIT_EN]               = ctrlQ.enable;
    ctrlView[BIT_MODE]             = ctrlQ.gated;
    ctrlView[BIT_POL]              = ctrlQ.polarity;
    ctrlView[BIT_CC]               = ctrlQ.ccSel;
    ctrlView[RATE_LO +: RATE_W]    = ctrlQ.rate;
  end

  assign busRdata = (busAddr == ADDR_COUNT) ? countQ : ctrlView;
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pacc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              pulseIn,
  output logic              ovfPulse
);
  ctrl_t             ctrlQ;
  strobe_t           strobe;
  logic [DATA_W-1:0] countQ;

  pacc_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .PRESCALE_W (PRESCALE_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busWdata(busWdata),
    .pulseIn (pulseIn),
    .ctrlQ   (ctrlQ),
    .strobe  (strobe)
  );

  pacc_datapath i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ctrlQ   (ctrlQ),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .countQ  (countQ),
    .ovfPulse(ovfPulse)
  );
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker
  import pacc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [DATA_W-1:0] busWdata,
  input logic              enable,
  input logic [DATA_W-1:0] countQ,
  input logic              ovfPulse
);
  logic cntWr;
  assign cntWr = busWr && (busAddr == ADDR_COUNT);

  // R10: overflow strobe lasts one cycle
  a_r10_ovf_single: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse);

  // R10: while the strobe is high the count has wrapped to zero
  a_r10_ovf_zero: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (countQ == '0));

  // R8: a bus write to the count always lands
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (countQ == $past(busWdata)));

  // R8: without a write the count moves by at most one
  a_r8_step_one: assert property (@(posedge clk) disable iff (!rstN)
    !cntWr |=> (countQ == $past(countQ)) || (countQ == $past(countQ) + 8'd1));

  // R3: disabled accumulator holds its count
  a_r3_disabled_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !cntWr) |=> (countQ == $past(countQ)));
endmodule

bind pulse_accum pacc_checker i_pacc_checker (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWr   (busWr),
  .busWdata(busWdata),
  .enable  (ctrlQ.enable),
  .countQ  (countQ),
  .ovfPulse(ovfPulse)
);

// File: tb/test_pulse_accum.sv
`timescale 1ns/1ps
module test_pulse_accum;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busAddr = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       pulseIn = 1'b0;
  logic       ovfPulse;

  int checks = 0;
  int errors = 0;
  int ovfSeen = 0;
  bit finished = 1'b0;

  // control encodings: bit6 enable, bit5 mode, bit4 polarity
  localparam logic [7:0] EV_FALL = 8'h40;
  localparam logic [7:0] EV_RISE = 8'h50;
  localparam logic [7:0] GT_POL0 = 8'h60;
  localparam logic [7:0] GT_POL1 = 8'h70;

  always #4 clk = ~clk;

  pulse_accum i_pulse_accum (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .pulseIn(pulseIn),
    .ovfPulse(ovfPulse)
  );

  always @(negedge clk) if (ovfPulse) ovfSeen++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic setPin(input logic v);
    @(negedge clk);
    pulseIn = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] v;
    readReg(1'b0, v);
    check("R1 reset ctrl", v, 8'h00);
    writeReg(1'b0, 8'hFF);
    readReg(1'b0, v);
    check("R1 R2 reserved bits", v, 8'h77);
    writeReg(1'b1, 8'h5A);
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk); rstN = 1'b1;
    readReg(1'b1, v);
    check("R9 count kept over reset", v, 8'h5A);
    readReg(1'b0, v);
    check("R1 ctrl cleared", v, 8'h00);
  endtask

  task automatic testDisabled();
    logic [7:0] v;
    writeReg(1'b0, 8'h10);
    writeReg(1'b1, 8'h20);
    setPin(1'b1); setPin(1'b0); setPin(1'b1); setPin(1'b0);
    repeat (200) @(negedge clk);
    readReg(1'b1, v);
    check("R3 disabled", v, 8'h20);
  endtask

  task automatic testEvent(input logic [7:0] cfg, input string req, input logic [7:0] afterRise);
    logic [7:0] v;
    pulseIn = 1'b0;
    writeReg(1'b0, cfg);
    writeReg(1'b1, 8'h10);
    setPin(1'b1);
    readReg(1'b1, v);
    check(req, v, afterRise);
    setPin(1'b0);
    readReg(1'b1, v);
    check(req, v, 8'h11);
  endtask

  task automatic testSyncDelay();
    logic [7:0] v;
    pulseIn = 1'b0;
    writeReg(1'b0, EV_RISE);
    writeReg(1'b1, 8'h30);
    busAddr = 1'b1;
    @(negedge clk); pulseIn = 1'b1;
    @(posedge clk); @(posedge clk); #1 v = busRdata;
    check("R11 not yet counted", v, 8'h30);
    @(posedge clk); #1 v = busRdata;
    check("R11 counted at k+2", v, 8'h31);
    setPin(1'b0);
  endtask

  task automatic testGated(input logic [7:0] cfg, input logic openLvl, input int periods, input string req);
    logic [7:0] v;
    @(negedge clk); pulseIn = ~openLvl;
    writeReg(1'b0, cfg);
    writeReg(1'b1, 8'h00);
    repeat (300) @(negedge clk);
    readReg(1'b1, v);
    check({req, " closed gate inhibits"}, v, 8'h00);
    @(negedge clk); pulseIn = openLvl;
    repeat (64 * periods) @(negedge clk);
    pulseIn = ~openLvl;
    repeat (10) @(negedge clk);
    readReg(1'b1, v);
    check({req, " open window ticks"}, v, 8'(periods));
  endtask

  task automatic testWriteWins();
    int bad = 0;
    logic [7:0] worst = 8'h50;
    @(negedge clk); pulseIn = 1'b1;
    writeReg(1'b0, GT_POL0);
    repeat (5) @(negedge clk);
    busAddr = 1'b1; busWdata = 8'h50; busWr = 1'b1;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      #1 if (busRdata !== 8'h50) begin bad++; worst = busRdata; end
    end
    busWr = 1'b0;
    check("R8 write beats tick", worst, 8'h50);
    repeat (140) @(negedge clk);
    readReg(1'b1, worst);
    checks++;
    if (worst < 8'h51 || worst > 8'h53) begin
      errors++;
      $display("FAIL R8 counting after write actual=%02h expected=51..53", worst);
    end
    if (bad != 0) $display("R8 mismatching cycles: %0d", bad);
  endtask

  task automatic testOverflow();
    logic [7:0] v;
    pulseIn = 1'b0;
    writeReg(1'b0, EV_RISE);
    setPin(1'b0);
    ovfSeen = 0;
    writeReg(1'b1, 8'hFE);
    writeReg(1'b1, 8'h00);
    writeReg(1'b1, 8'hFE);
    check("R10 no strobe on write", 8'(ovfSeen), 8'd0);
    setPin(1'b1); setPin(1'b0);
    check("R10 no strobe at FF", 8'(ovfSeen), 8'd0);
    setPin(1'b1);
    readReg(1'b1, v);
    check("R10 wrapped count", v, 8'h00);
    check("R10 single strobe", 8'(ovfSeen), 8'd1);
    setPin(1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDisabled();
    testEvent(EV_FALL, "R4 falling edge", 8'h10);
    testEvent(EV_RISE, "R5 rising edge", 8'h11);
    testSyncDelay();
    testGated(GT_POL0, 1'b1, 5, "R6");
    testGated(GT_POL1, 1'b0, 10, "R7");
    testWriteWins();
    testOverflow();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule